// File: doc/BRIEF.md
# Multi-format serial audio transmitter

The block serializes one stereo pair of signed 24-bit samples per frame onto a single serial data line. It is framed by a bit clock and a word-select clock. It can generate both clocks itself (clock master) or follow clocks supplied from outside (clock slave). A 2-bit format code selects one of four word layouts inside each channel half. A single pre-aligned shift register serves every layout.

Samples enter as a left/right pair qualified by a one-cycle valid strobe and are held until used. Each channel word is copied into the shifter at the word-select edge that opens that channel's half-frame, so a new pair that arrives mid-half never disturbs the word being sent. All logic runs on one system clock. In slave mode the external clocks are resynchronized and their edges detected, so they must be much slower than the system clock. A power-down input clears the digital state and silences every output.

Top module: `ser_audio_tx`

## Requirements
- R1: Format code 00 (left-aligned): the sample MSB occupies the first bit slot of the half-frame, the 24 bits follow MSB first in two's complement, and all later slots carry 0.
- R2: Format code 01 (one-bit-delayed): the first slot of each half carries 0 and the MSB occupies the second slot. In a 24-slot half the LSB does not fit and is not sent.
- R3: Format code 10 (right-aligned, 24 bits): the LSB occupies the last slot before the next word-select change, and the slots ahead of the MSB carry 0.
- R4: Format code 11 (right-aligned, 20 bits): only sample bits 23..4 are sent, with bit 4 in the last slot of the half and zeros ahead of bit 23.
- R5: For codes 00, 10 and 11 the left word goes out while word-select is high. For code 01 it goes out while word-select is low.
- R6: In master mode bck_o has a period of 2*BCK_HALF system clocks, lrck_o toggles every 32 bit-clock periods (a 64-bit frame), and lrck_o changes only right after a bck_o falling edge.
- R7: In slave mode the block accepts frames of either 64 or 48 bit-clock periods. It takes the half length from the half just ended, so the right-aligned formats end exactly on the last slot.
- R8: Serial data changes only after a bit-clock falling edge and stays stable while the bit clock is high.
- R9: While pd_i is high, sdata_o, bck_o and lrck_o are low from the next cycle on, and the held samples are cleared.
- R10: A pair presented on valid_i is held, and each channel word is taken at that channel's word-select edge. A pair that arrives during a half does not change the word being sent.
- R11: During reset sdata_o, bck_o and lrck_o are low.
- R12: In slave mode bck_o and lrck_o are held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pd_i | input | 1 | Power-down, active high |
| master_i | input | 1 | 1: block generates bit and word clocks; 0: follows bck_i/lrck_i |
| fmt_i | input | 2 | Word layout code (00, 01, 10, 11 as in R1 to R4) |
| valid_i | input | 1 | Strobe qualifying left_i/right_i |
| left_i | input | SAMPLE_W | Left sample, two's complement |
| right_i | input | SAMPLE_W | Right sample, two's complement |
| bck_i | input | 1 | External bit clock (slave) |
| lrck_i | input | 1 | External word-select clock (slave) |
| bck_o | output | 1 | Generated bit clock (master) |
| lrck_o | output | 1 | Generated word-select clock (master) |
| sdata_o | output | 1 | Serial data |

## Verification
In master mode sdata_o moves one system clock after bck_o falls. In slave mode it moves SYNC_STAGES+1 clocks after a bck_i fall, because the input passes through the synchronizer and the edge detector. Both delays are well inside half a bit period, so the bench samples the data line on the system-clock edge at which it sees the bit clock rise. The data is half a bit period old there and cannot yet have moved for the next slot. The bench drives inputs after rising clock edges and samples on falling ones. It skips the first two half-frames after each configuration change, while the half-length measurement locks. A new sample pair is presented at slot 11 of every right half, and the expected word for each half is fixed when that half opens.

// File: rtl/ser_audio_pkg.sv
package ser_audio_pkg;

  typedef enum logic [1:0] {
    FMT_LEFT    = 2'b00,
    FMT_DELAY1  = 2'b01,
    FMT_RIGHT24 = 2'b10,
    FMT_RIGHT20 = 2'b11
  } fmt_e;

  // bit-clock / word-select events in the system clock domain
  typedef struct packed {
    logic fall;     // bit clock fell this cycle
    logic ws_edge;  // word select changed this cycle
    logic ws;       // current word select level
  } bus_ev_t;

endpackage

// File: rtl/ser_audio_clkgen.sv
module ser_audio_clkgen
  import ser_audio_pkg::*;
#(
  parameter int BCK_HALF   = 4,
  parameter int HALF_SLOTS = 32
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    clr_i,
  output logic    bck_o,
  output logic    ws_o,
  output bus_ev_t ev_o
);

  localparam int DIV_W  = (BCK_HALF > 1) ? $clog2(BCK_HALF) : 1;
  localparam int SLOT_W = (HALF_SLOTS > 1) ? $clog2(HALF_SLOTS) : 1;
  localparam logic [DIV_W-1:0]  DIV_LAST  = DIV_W'(BCK_HALF - 1);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(HALF_SLOTS - 1);

  logic [DIV_W-1:0]  div_q;
  logic [SLOT_W-1:0] slot_q;
  logic bck_q, ws_q, fall_q, edge_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      slot_q <= SLOT_LAST;
      bck_q  <= 1'b0;
      ws_q   <= 1'b0;
      fall_q <= 1'b0;
      edge_q <= 1'b0;
    end else if (clr_i) begin
      div_q  <= '0;
      slot_q <= SLOT_LAST;
      bck_q  <= 1'b0;
      ws_q   <= 1'b0;
      fall_q <= 1'b0;
      edge_q <= 1'b0;
    end else begin
      fall_q <= 1'b0;
      edge_q <= 1'b0;
      if (div_q == DIV_LAST) begin
        div_q <= '0;
        bck_q <= ~bck_q;
        if (bck_q) begin
          // falling edge: next slot; word select moves with it
          fall_q <= 1'b1;
          if (slot_q == SLOT_LAST) begin
            slot_q <= '0;
            ws_q   <= ~ws_q;
            edge_q <= 1'b1;
          end else begin
            slot_q <= slot_q + 1'b1;
          end
        end
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  assign bck_o = bck_q;
  assign ws_o  = ws_q;

  always_comb begin
    ev_o.fall    = fall_q;
    ev_o.ws_edge = edge_q;
    ev_o.ws      = ws_q;
  end

endmodule

// File: rtl/ser_audio_insync.sv
module ser_audio_insync
  import ser_audio_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    bck_i,
  input  logic    ws_i,
  output bus_ev_t ev_o
);

  logic [STAGES-1:0] bck_s, ws_s;
  logic bck_d, ws_d;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          bck_s <= '0;
          ws_s  <= '0;
        end else begin
          bck_s <= bck_i;
          ws_s  <= ws_i;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          bck_s <= '0;
          ws_s  <= '0;
        end else begin
          bck_s <= {bck_s[STAGES-2:0], bck_i};
          ws_s  <= {ws_s[STAGES-2:0], ws_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bck_d <= 1'b0;
      ws_d  <= 1'b0;
    end else begin
      bck_d <= bck_s[STAGES-1];
      ws_d  <= ws_s[STAGES-1];
    end
  end

  always_comb begin
    ev_o.fall    = bck_d & ~bck_s[STAGES-1];
    ev_o.ws_edge = ws_d ^ ws_s[STAGES-1];
    ev_o.ws      = ws_s[STAGES-1];
  end

endmodule

// File: rtl/ser_audio_shifter.sv
module ser_audio_shifter
  import ser_audio_pkg::*;
#(
  parameter int SAMPLE_W    = 24,
  parameter int NARROW_W    = 20,
  parameter int SLOTS_LONG  = 32,
  parameter int SLOTS_SHORT = 24
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  fmt_e                fmt_i,
  input  logic                force_long_i,
  input  bus_ev_t             ev_i,
  input  logic                valid_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  output logic                sdata_o
);

  localparam int SR_W     = SLOTS_LONG;
  localparam int CNT_W    = $clog2(SLOTS_LONG + 1) + 1;
  localparam int SPLIT    = (SLOTS_LONG + SLOTS_SHORT) / 2;
  localparam int LEFT_SH  = SR_W - SAMPLE_W;
  localparam int DELAY_SH = LEFT_SH - 1;
  localparam int SHORT_SH = SR_W - SLOTS_SHORT;

  logic [SAMPLE_W-1:0] hold_l_q, hold_r_q;
  logic [SR_W-1:0]     sr_q;
  logic [CNT_W-1:0]    cnt_q;
  logic                sdata_q;

  logic                short_half, left_now;
  logic [SAMPLE_W-1:0] word;
  logic [SR_W-1:0]     wide, narrow, load;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_l_q <= '0;
      hold_r_q <= '0;
    end else if (clr_i) begin
      hold_l_q <= '0;
      hold_r_q <= '0;
    end else if (valid_i) begin
      hold_l_q <= left_i;
      hold_r_q <= right_i;
    end
  end

  // length of the half that is ending, taken at the word-select edge
  always_comb begin
    short_half = !force_long_i && ((int'(cnt_q) + 1) <= SPLIT);
    left_now   = (fmt_i == FMT_DELAY1) ? !ev_i.ws : ev_i.ws;
    word       = left_now ? hold_l_q : hold_r_q;
    wide       = SR_W'(word);
    narrow     = SR_W'(word[SAMPLE_W-1 -: NARROW_W]);
    unique case (fmt_i)
      FMT_LEFT:    load = wide << LEFT_SH;
      FMT_DELAY1:  load = wide << DELAY_SH;
      FMT_RIGHT24: load = short_half ? (wide << SHORT_SH) : wide;
      FMT_RIGHT20: load = short_half ? (narrow << SHORT_SH) : narrow;
      default:     load = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q    <= '0;
      cnt_q   <= '0;
      sdata_q <= 1'b0;
    end else if (clr_i) begin
      sr_q    <= '0;
      cnt_q   <= '0;
      sdata_q <= 1'b0;
    end else if (ev_i.ws_edge) begin
      sdata_q <= load[SR_W-1];
      sr_q    <= load << 1;
      cnt_q   <= '0;
    end else if (ev_i.fall) begin
      sdata_q <= sr_q[SR_W-1];
      sr_q    <= sr_q << 1;
      if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign sdata_o = sdata_q;

endmodule

// File: rtl/ser_audio_tx.sv
module ser_audio_tx
  import ser_audio_pkg::*;
#(
  parameter int SAMPLE_W    = 24,
  parameter int NARROW_W    = 20,
  parameter int SLOTS_LONG  = 32,
  parameter int SLOTS_SHORT = 24,
  parameter int BCK_HALF    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                pd_i,
  input  logic                master_i,
  input  logic [1:0]          fmt_i,
  input  logic                valid_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  input  logic                bck_i,
  input  logic                lrck_i,
  output logic                bck_o,
  output logic                lrck_o,
  output logic                sdata_o
);

  bus_ev_t gen_ev, ext_ev, bus_ev;
  logic    gen_clr;

  assign gen_clr = pd_i | ~master_i;

  ser_audio_clkgen #(
    .BCK_HALF  (BCK_HALF),
    .HALF_SLOTS(SLOTS_LONG)
  ) clkgen_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (gen_clr),
    .bck_o (bck_o),
    .ws_o  (lrck_o),
    .ev_o  (gen_ev)
  );

  ser_audio_insync #(
    .STAGES(SYNC_STAGES)
  ) insync_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .bck_i (bck_i),
    .ws_i  (lrck_i),
    .ev_o  (ext_ev)
  );

  assign bus_ev = master_i ? gen_ev : ext_ev;

  ser_audio_shifter #(
    .SAMPLE_W   (SAMPLE_W),
    .NARROW_W   (NARROW_W),
    .SLOTS_LONG (SLOTS_LONG),
    .SLOTS_SHORT(SLOTS_SHORT)
  ) shifter_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (pd_i),
    .fmt_i       (fmt_e'(fmt_i)),
    .force_long_i(master_i),
    .ev_i        (bus_ev),
    .valid_i     (valid_i),
    .left_i      (left_i),
    .right_i     (right_i),
    .sdata_o     (sdata_o)
  );

endmodule

// File: rtl/ser_audio_tx_chk.sv
module ser_audio_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic pd_i,
  input logic master_i,
  input logic bck_o,
  input logic lrck_o,
  input logic sdata_o
);

  // R11: quiet outputs while reset is applied
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_rst_quiet_r11: assert (!sdata_o && !bck_o && !lrck_o)
        else $error("outputs active in reset");
    end
  end

  p_pd_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_i |=> (!sdata_o && !bck_o && !lrck_o));

  p_slave_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_i |=> (!bck_o && !lrck_o));

  p_data_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && $past(master_i) && !pd_i && !$past(pd_i) && bck_o && $past(bck_o))
    |-> $stable(sdata_o));

  p_ws_on_fall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && $past(master_i) && !$past(pd_i) && (lrck_o != $past(lrck_o)))
    |-> (!bck_o && $past(bck_o)));

endmodule

bind ser_audio_tx ser_audio_tx_chk chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .pd_i    (pd_i),
  .master_i(master_i),
  .bck_o   (bck_o),
  .lrck_o  (lrck_o),
  .sdata_o (sdata_o)
);

// File: tb/ser_audio_tx_tb_top.sv
`timescale 1ns/1ps
module ser_audio_tx_tb_top;

  localparam int BCK_HALF = 4;
  localparam int SH       = 6;   // slave bit clock half period, system clocks
  localparam int WDOG     = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pd = 1'b0, master = 1'b1, valid = 1'b0;
  logic [1:0]  fmt = 2'b00;
  logic [23:0] left = '0, right = '0;
  logic bck_d = 1'b0, lr_d = 1'b0;
  logic bck_o, lrck_o, sdata_o;

  always #4 clk = ~clk;

  ser_audio_tx dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pd_i(pd), .master_i(master), .fmt_i(fmt),
    .valid_i(valid), .left_i(left), .right_i(right),
    .bck_i(bck_d), .lrck_i(lr_d),
    .bck_o(bck_o), .lrck_o(lrck_o), .sdata_o(sdata_o)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  bit timeout = 0;
  int slave_slots = 32;

  // monitor state
  bit mon_on = 0;
  logic prev_bck, cur_lr, chan_left;
  bit active;
  int slot, halves, last_rise, period, k;
  logic [31:0] got;
  logic [23:0] exp_word, mdl_l, mdl_r;

  task automatic chk(bit ok, string req, longint act, longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h (t=%0t)", req, act, expv, $time);
    end
  endtask

  function automatic logic [31:0] exp_bits(logic [1:0] f, int n, logic [23:0] w);
    logic [31:0] r = '0;
    for (int s = 0; s < n; s++) begin
      int idx;
      case (f)
        2'b00:   idx = 23 - s;
        2'b01:   idx = 24 - s;
        2'b10:   idx = 23 - (s - (n - 24));
        default: idx = 23 - (s - (n - 20));
      endcase
      if (idx >= 0 && idx <= 23) r[s] = w[idx];
    end
    return r;
  endfunction

  function automatic logic [23:0] pair_l(int i);
    return 24'((i * 24'h3B9AC1 + 24'h812345) & 24'hFFFFFF);
  endfunction
  function automatic logic [23:0] pair_r(int i);
    return ~pair_l(i) ^ 24'(i << 3);
  endfunction

  task automatic new_pair();
    k++;
    mdl_l = pair_l(k);
    mdl_r = pair_r(k);
    left  = mdl_l;
    right = mdl_r;
    valid = 1'b1;
  endtask

  task automatic end_half();
    int n_exp;
    logic [31:0] e;
    halves++;
    if (halves <= 2) return;
    n_exp = master ? 32 : slave_slots;
    if (master) begin
      chk(slot == n_exp, "R6 slots per half", slot, n_exp);
      chk(period == 2 * BCK_HALF, "R6 bit clock period", period, 2 * BCK_HALF);
    end else begin
      chk(slot == n_exp, "R7 slots per half", slot, n_exp);
      chk(!bck_o && !lrck_o, "R12 clocks quiet in slave", {bck_o, lrck_o}, 0);
    end
    e = exp_bits(fmt, n_exp, exp_word);
    case (fmt)
      2'b00:   chk(got == e, "R1 R5 R10 R8 left-aligned half", got, e);
      2'b01:   chk(got == e, "R2 R5 R10 R8 delayed half", got, e);
      2'b10:   chk(got == e, "R3 R5 R10 R8 right24 half", got, e);
      default: chk(got == e, "R4 R5 R10 R8 right20 half", got, e);
    endcase
  endtask

  task automatic mon_step();
    logic bb, bl;
    bb = master ? bck_o : bck_d;
    bl = master ? lrck_o : lr_d;
    if (bb && !prev_bck) begin
      period = cyc - last_rise;
      last_rise = cyc;
      if (bl != cur_lr) begin
        if (active) end_half();
        cur_lr = bl;
        active = 1;
        slot = 0;
        got = '0;
        chan_left = (fmt == 2'b01) ? !bl : bl;
        exp_word = chan_left ? mdl_l : mdl_r;
      end
      if (active) begin
        if (slot < 32) got[slot] = sdata_o;
        slot++;
        if (slot == 11 && !chan_left) new_pair();
      end
    end
    prev_bck = bb;
  endtask

  task automatic tick();
    @(negedge clk);
    cyc++;
    if (cyc > WDOG) timeout = 1;
    valid = 1'b0;
    if (mon_on) mon_step();
  endtask

  task automatic run_cfg(bit m, logic [1:0] f, int ss);
    bit ok;
    pd = 1'b1;
    master = m;
    fmt = f;
    slave_slots = ss;
    tick();
    tick();
    ok = 1;
    for (int i = 0; i < 8; i++) begin
      tick();
      if (sdata_o || bck_o || lrck_o) ok = 0;
    end
    chk(ok, "R9 power-down quiet", {sdata_o, bck_o, lrck_o}, 0);
    pd = 1'b0;
    new_pair();
    prev_bck = master ? bck_o : bck_d;
    cur_lr = master ? lrck_o : lr_d;
    active = 0;
    halves = 0;
    last_rise = cyc;
    mon_on = 1;
    while (halves < 9 && !timeout) tick();
    mon_on = 0;
  endtask

  // external bit/word clocks for slave mode
  initial begin
    wait (rst_n);
    forever begin
      @(posedge clk); #1;
      lr_d = ~lr_d;
      for (int s = 0; s < slave_slots; s++) begin
        if (s != 0) begin
          @(posedge clk); #1;
        end
        bck_d = 1'b0;
        repeat (SH) @(posedge clk);
        #1 bck_d = 1'b1;
        repeat (SH - 1) @(posedge clk);
      end
    end
  end

  initial begin
    k = 0;
    repeat (3) tick();
    chk(!sdata_o && !bck_o && !lrck_o, "R11 reset state", {sdata_o, bck_o, lrck_o}, 0);
    rst_n = 1'b1;
    tick();
    for (int m = 1; m >= 0; m--) begin
      for (int sl = 0; sl < 2; sl++) begin
        if (m == 1 && sl == 1) continue;
        for (int f = 0; f < 4; f++) begin
          if (!timeout) run_cfg(m[0], 2'(f), (sl == 0) ? 32 : 24);
        end
      end
    end
    if (timeout) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired act=%0d exp=%0d", cyc, WDOG);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule